// File: doc/BRIEF.md
# Comma-Aligning Word Deserializer with Alternating Byte Clocks

This block sits behind a clock/data recovery front end and runs on the recovered bit clock. It takes one serial bit per clock cycle and gathers the bits into 10-bit words. The first bit received in each word lands in output bit 0. When alignment is enabled, it watches the incoming stream for the comma pattern. This pattern is two zeros followed by five ones, in arrival order. When the pattern completes at an offset that is not the current word boundary, the boundary moves so that the comma arrives as one whole output word. Words after it then follow every ten bits.

Each word comes with a comma-detect flag. It also comes with one of two half-rate byte clocks, which are 180 degrees apart. Consecutive words are marked by rising edges of the two clocks in turn. The rising edge follows the word by one bit cycle, so the data is stable when the edge arrives. A comma word is always marked by byte clock 1. If the previous word was already marked by clock 1, that clock is pulled low for one bit cycle so that it can rise again on the comma. While the signal-detect input is low, the data output is held at all ones and the flag is low.

Top module: `cs_comma_deser`

## Requirements
- R1: While reset is asserted, word_out is all ones, comma_det is 0, and both byte_clk0 and byte_clk1 are 0. The boundary counter restarts, so the first word after reset is made of the first ten bits received.
- R2: Bit order and free running. word_out[i] holds the i-th received bit of a word, with bit 0 received earliest. With align_en low, word k after reset is made of bits 10k to 10k+9, and the boundary never moves.
- R3: A word is a comma word when word_out[6:0] == 7'b1111100, meaning received bits 0 and 1 are 0 and bits 2 to 6 are 1. Bits 9:7 are ignored. Example: 10'h17C.
- R4: With align_en high, a comma completing at any bit offset is presented as a whole word. It appears at the clock edge that samples its tenth bit. The following words appear every ten bits after it.
- R5: comma_det is high only together with a comma word, and only while align_en and sig_ok are high. With align_en low it stays low, even for comma-shaped words.
- R6: Word k after reset is marked by a rising edge of byte_clk1 when k is even and of byte_clk0 when k is odd. The edge comes one bit cycle after word_out changes. The two clocks are never high together, and each stays high for one word period in steady state.
- R7: A comma word is always marked by a rising edge of byte_clk1, even when the previous word was also marked by byte_clk1. The words after it alternate again, starting with byte_clk0.
- R8: In the cycle after sig_ok is seen low, word_out is all ones and comma_det is 0. After sig_ok returns high, the next word boundary presents received data again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Recovered bit clock, one serial bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| ser_in | input | 1 | Serial data bit |
| align_en | input | 1 | Enables comma search and word realignment |
| sig_ok | input | 1 | Signal-detect indication; low forces data to all ones |
| word_out | output | 10 | Parallel word, bit 0 received first |
| comma_det | output | 1 | High with a word that holds an aligned comma |
| byte_clk0 | output | 1 | Half-rate byte clock marking odd words |
| byte_clk1 | output | 1 | Half-rate byte clock marking even words and every comma |

## Verification
The bench sends a comma at every offset from 0 to 19 bits after reset. A design that delays realignment by one boundary, or that misses some offsets, would present the comma late or not at all. A second comma lands on the slot that byte clock 1 just marked. A byte-clock generator that only toggles would then mark that comma with byte clock 0. All 1024 word values are sent with alignment off, including comma-shaped words that straddle boundaries. A design that realigns or raises the flag while disabled would scramble every later word. The signal-detect test sends a comma while the signal is lost. This catches data that leaks through, or a flag raised without valid data.

// File: rtl/cs_pkg.sv
package cs_pkg;

    localparam int unsigned WORD_W   = 10;
    localparam int unsigned MARK_LEN = 7;
    // arrival order 0,0,1,1,1,1,1 -> bit i is the i-th received bit
    localparam logic [MARK_LEN-1:0] MARK_BITS = 7'b1111100;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        word_t data;
        logic  comma;
    } out_pkt_t;

    typedef enum logic {
        SEL_CLK0 = 1'b0,
        SEL_CLK1 = 1'b1
    } bclk_sel_e;

    function automatic word_t all_ones();
        return '1;
    endfunction

endpackage

// File: rtl/cs_shift_window.sv
module cs_shift_window #(
    parameter int unsigned W = cs_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         bit_in,
    output logic [W-1:0] win_next
);
    logic [W-1:0] win_q;

    // newest bit enters at the top, so bit 0 is the oldest of the last W
    assign win_next = {bit_in, win_q[W-1:1]};

    always_ff @(posedge clk) begin
        if (rst) win_q <= '0;
        else     win_q <= win_next;
    end
endmodule

// File: rtl/cs_comma_search.sv
module cs_comma_search #(
    parameter int unsigned          MLEN  = cs_pkg::MARK_LEN,
    parameter logic [MLEN-1:0]      MBITS = cs_pkg::MARK_BITS
) (
    input  logic [MLEN-1:0] cand,
    output logic            match
);
    logic [MLEN-1:0] hit;

    for (genvar i = 0; i < MLEN; i++) begin : g_cmp
        assign hit[i] = (cand[i] == MBITS[i]);
    end

    assign match = &hit;
endmodule

// File: rtl/cs_boundary.sv
module cs_boundary #(
    parameter int unsigned W = cs_pkg::WORD_W
) (
    input  logic clk,
    input  logic rst,
    input  logic align_en,
    input  logic match,
    output logic emit,
    output logic realign
);
    localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    logic [CW-1:0] cnt_q;
    logic          at_end;

    assign at_end  = (cnt_q == LAST);
    assign realign = align_en & match & ~at_end;
    assign emit    = at_end | (align_en & match);

    always_ff @(posedge clk) begin
        if (rst)       cnt_q <= '0;
        else if (emit) cnt_q <= '0;
        else           cnt_q <= cnt_q + 1'b1;
    end

    // R4: the boundary counter never passes the word length
    a_r4_count_bound: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= LAST);

    // R4: a realignment restarts the count from zero
    a_r4_realign_restarts: assert property (@(posedge clk) disable iff (rst)
        realign |=> (cnt_q == '0));
endmodule

// File: rtl/cs_byte_clocks.sv
module cs_byte_clocks (
    input  logic clk,
    input  logic rst,
    input  logic emit,
    input  logic comma_word,
    output logic bclk0,
    output logic bclk1
);
    import cs_pkg::*;

    logic      c0_q, c1_q;
    logic      pend_v_q;
    bclk_sel_e pend_sel_q;
    bclk_sel_e last_sel_q;
    bclk_sel_e sel;
    logic      n0, n1;

    always_comb begin
        sel = comma_word ? SEL_CLK1
                         : ((last_sel_q == SEL_CLK1) ? SEL_CLK0 : SEL_CLK1);
        n0 = c0_q;
        n1 = c1_q;
        if (pend_v_q) begin
            n1 = (pend_sel_q == SEL_CLK1);
            n0 = (pend_sel_q == SEL_CLK0);
        end
        // a comma on a clock that is already high: drop it for one bit cycle
        if (emit && sel == SEL_CLK1 && n1) n1 = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c0_q       <= 1'b0;
            c1_q       <= 1'b0;
            pend_v_q   <= 1'b0;
            pend_sel_q <= SEL_CLK0;
            last_sel_q <= SEL_CLK0;
        end else begin
            c0_q     <= n0;
            c1_q     <= n1;
            pend_v_q <= emit;
            if (emit) begin
                pend_sel_q <= sel;
                last_sel_q <= sel;
            end
        end
    end

    assign bclk0 = c0_q;
    assign bclk1 = c1_q;

    // R6: the two byte clocks are never high together
    a_r6_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(c0_q && c1_q));

    // R7: a comma word is followed by a rising edge of clock 1
    a_r7_comma_on_clk1: assert property (@(posedge clk) disable iff (rst)
        (emit && comma_word) |=> ##1 $rose(c1_q));
endmodule

// File: rtl/cs_comma_deser.sv
module cs_comma_deser #(
    parameter int unsigned W = cs_pkg::WORD_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ser_in,
    input  logic         align_en,
    input  logic         sig_ok,
    output logic [W-1:0] word_out,
    output logic         comma_det,
    output logic         byte_clk0,
    output logic         byte_clk1
);
    import cs_pkg::*;

    localparam int unsigned MLEN = MARK_LEN;

    logic [W-1:0] win_next;
    logic         match;
    logic         emit;
    logic         realign;
    out_pkt_t     out_q;

    cs_shift_window #(.W(W)) u_win (
        .clk      (clk),
        .rst      (rst),
        .bit_in   (ser_in),
        .win_next (win_next)
    );

    cs_comma_search #(.MLEN(MLEN), .MBITS(MARK_BITS)) u_search (
        .cand  (win_next[MLEN-1:0]),
        .match (match)
    );

    cs_boundary #(.W(W)) u_bound (
        .clk      (clk),
        .rst      (rst),
        .align_en (align_en),
        .match    (match),
        .emit     (emit),
        .realign  (realign)
    );

    cs_byte_clocks u_bclk (
        .clk        (clk),
        .rst        (rst),
        .emit       (emit),
        .comma_word (align_en & match),
        .bclk0      (byte_clk0),
        .bclk1      (byte_clk1)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q.data  <= all_ones();
            out_q.comma <= 1'b0;
        end else if (!sig_ok) begin
            out_q.data  <= all_ones();
            out_q.comma <= 1'b0;
        end else if (emit) begin
            out_q.data  <= win_next;
            out_q.comma <= align_en & match;
        end else begin
            out_q.comma <= out_q.comma & align_en;
        end
    end

    assign word_out  = out_q.data;
    assign comma_det = out_q.comma;

    // R8: lost signal forces ones and clears the flag
    a_r8_forced_ones: assert property (@(posedge clk) disable iff (rst)
        $past(!sig_ok) |-> (word_out == '1 && !comma_det));

    // R5: the flag never survives a cycle with alignment off
    a_r5_flag_needs_align: assert property (@(posedge clk) disable iff (rst)
        $past(!align_en) |-> !comma_det);

    // R3: the flag only accompanies a word carrying the comma pattern
    a_r3_flag_has_mark: assert property (@(posedge clk) disable iff (rst)
        comma_det |-> (word_out[MLEN-1:0] == MARK_BITS));

    // R4: a realignment presents the comma word at once
    a_r4_realign_presents: assert property (@(posedge clk) disable iff (rst)
        (realign && sig_ok) |=> comma_det);
endmodule

// File: tb/cs_comma_deser_test.sv
module cs_comma_deser_test;

    logic       clk = 1'b0;
    logic       rst;
    logic       ser_in;
    logic       align_en;
    logic       sig_ok;
    logic [9:0] word_out;
    logic       comma_det;
    logic       byte_clk0;
    logic       byte_clk1;

    cs_comma_deser uut (
        .clk       (clk),
        .rst       (rst),
        .ser_in    (ser_in),
        .align_en  (align_en),
        .sig_ok    (sig_ok),
        .word_out  (word_out),
        .comma_det (comma_det),
        .byte_clk0 (byte_clk0),
        .byte_clk1 (byte_clk1)
    );

    always #10 clk = ~clk;

    localparam logic [9:0] CM = 10'h17C;

    int   n_chk = 0;
    int   n_bad = 0;
    int   stepno = 0;
    int   nrise = 0;
    int   both_high = 0;
    logic p0 = 1'b0, p1 = 1'b0;
    logic [9:0] rw [0:2047];
    logic       rf [0:2047];
    logic       rc [0:2047];
    int         rstep [0:2047];

    task automatic chk(input logic ok, input string req,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic sample();
        stepno++;
        if (byte_clk0 && byte_clk1) both_high++;
        if ((byte_clk0 && !p0) || (byte_clk1 && !p1)) begin
            if (nrise < 2048) begin
                rw[nrise]    = word_out;
                rf[nrise]    = comma_det;
                rc[nrise]    = byte_clk1 && !p1;
                rstep[nrise] = stepno;
            end
            nrise++;
        end
        p0 = byte_clk0;
        p1 = byte_clk1;
    endtask

    task automatic step(input logic b);
        ser_in = b;
        @(posedge clk);
        #5;
        sample();
    endtask

    task automatic send_word(input logic [9:0] w);
        for (int b = 0; b < 10; b++) step(w[b]);
    endtask

    task automatic do_reset(input logic al, input logic so);
        rst = 1'b1; align_en = al; sig_ok = so; ser_in = 1'b0;
        repeat (3) @(posedge clk);
        #5;
        rst = 1'b0;
        p0 = 1'b0; p1 = 1'b0; nrise = 0; stepno = 0;
    endtask

    initial begin
        #4000000;
        n_bad++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] ew [1:5];
        logic       ec [1:5];
        logic       ef [1:5];
        int         found;
        int         lastc;
        int         r6_bad;
        int         first_step;

        // R1: reset state
        rst = 1'b1; align_en = 1'b1; sig_ok = 1'b1; ser_in = 1'b1;
        repeat (3) @(posedge clk);
        #5;
        chk(word_out == 10'h3FF, "R1 data", word_out, 10'h3FF);
        chk(!comma_det, "R1 flag", comma_det, 0);
        chk(!byte_clk0 && !byte_clk1, "R1 clocks", {byte_clk1, byte_clk0}, 0);

        // R2 R5 R6: every word value, alignment off, boundary fixed
        do_reset(1'b0, 1'b1);
        for (int k = 0; k < 1024; k++) send_word(10'(k));
        repeat (12) step(1'b0);
        chk(nrise >= 1024, "R2 word count", nrise, 1024);
        r6_bad = 0;
        for (int k = 0; k < 1024; k++) begin
            chk(rw[k] == 10'(k), "R2 word", rw[k], k);
            chk(!rf[k], "R5 flag off", rf[k], 0);
            if (rc[k] != (k % 2 == 0) || rstep[k] != 10 * k + 11) r6_bad++;
        end
        chk(r6_bad == 0, "R6 alternation/timing", r6_bad, 0);

        // R4 R7: comma at every offset, then a second comma on a clock-1 slot
        ew[1] = 10'h155; ec[1] = 1'b0; ef[1] = 1'b0;
        ew[2] = 10'h2AA; ec[2] = 1'b1; ef[2] = 1'b0;
        ew[3] = CM;      ec[3] = 1'b1; ef[3] = 1'b1;
        ew[4] = 10'h333; ec[4] = 1'b0; ef[4] = 1'b0;
        ew[5] = 10'h0CC; ec[5] = 1'b1; ef[5] = 1'b0;
        for (int s = 0; s < 20; s++) begin
            do_reset(1'b1, 1'b1);
            repeat (s) step(1'b0);
            send_word(CM);
            lastc = stepno;
            for (int j = 1; j <= 5; j++) send_word(ew[j]);
            repeat (12) step(1'b0);
            found = -1;
            for (int i = 0; i < nrise && i < 2048; i++)
                if (found < 0 && rc[i] && rf[i] && rw[i] == CM && rstep[i] == lastc + 1)
                    found = i;
            chk(found >= 0, "R4 comma aligned at offset", found, s);
            if (found >= 0) begin
                for (int j = 1; j <= 5; j++) begin
                    if (found + j < nrise)
                        chk(rw[found+j] == ew[j] && rc[found+j] == ec[j] &&
                            rf[found+j] == ef[j] && rstep[found+j] == lastc + 1 + 10 * j,
                            (j == 3) ? "R7 comma on clock 1" : "R4 R6 word after comma",
                            {rc[found+j], rf[found+j], rw[found+j]},
                            {ec[j], ef[j], ew[j]});
                    else
                        chk(1'b0, "R4 missing word", nrise, found + j);
                end
            end
        end

        // R8: lost signal with a comma in flight
        do_reset(1'b1, 1'b0);
        r6_bad = 0;
        repeat (3) step(1'b0);
        for (int b = 0; b < 10; b++) begin
            step(CM[b]);
            if (word_out != 10'h3FF || comma_det) r6_bad++;
        end
        for (int b = 0; b < 7; b++) begin
            step(1'b0);
            if (word_out != 10'h3FF || comma_det) r6_bad++;
        end
        chk(r6_bad == 0, "R8 forced ones", r6_bad, 0);

        // R8: recovery at the next boundary
        do_reset(1'b0, 1'b0);
        send_word(10'h0F0);
        sig_ok = 1'b1;
        send_word(10'h1A5);
        repeat (3) step(1'b0);
        first_step = nrise;
        chk(first_step >= 2, "R8 rises", first_step, 2);
        chk(rw[0] == 10'h3FF, "R8 word during loss", rw[0], 10'h3FF);
        chk(rw[1] == 10'h1A5, "R8 word after recovery", rw[1], 10'h1A5);

        chk(both_high == 0, "R6 exclusive clocks", both_high, 0);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule